// File: doc/BRIEF.md
# Single-Cycle Fast Integer ALU Subset

This block is a one-cycle arithmetic and logic unit that sits beside a slower multi-cycle 64-bit ALU in an execute stage. It recognises a small set of frequent operations and returns their result one clock after issue. Alongside the result it raises a fast-valid flag. The flag tells the pipeline that the value can be forwarded now. When the flag is low, the pipeline must wait for the slow unit, which receives every operation regardless.

The supported set covers four groups. The first two are 32-bit add and subtract, with the 32-bit result either sign-extended or zero-extended to 64 bits. The third is 64-bit add and subtract, taken only when both operands lie in a narrow window around zero. The fourth is full-width AND, OR and XOR. The window spans [-2^30, 2^30), so a 64-bit sum or difference of two window operands always fits in signed 32 bits. Because of this, the block never needs a carry chain longer than 32 bits. Any operation or operand pair the block cannot finish quickly is declined, and the slow unit produces the result.

Top module: `qalu_fast`

## Requirements
- R1: Opcode 4'd0 (add) and 4'd1 (subtract, a minus b) produce the low 32 bits of the sum or difference. Bit 31 of that value is copied into bits 63:32. The flag is raised.
- R2: Opcode 4'd2 (add) and 4'd3 (subtract) produce the low 32 bits of the sum or difference, with bits 63:32 zero. The flag is raised.
- R3: Opcode 4'd4 (add) and 4'd5 (subtract) are accepted when both operands, read as signed 64-bit values, lie in [-2^30, 2^30). In that case the result is the exact signed 64-bit sum or difference and the flag is raised.
- R4: For opcode 4'd4 or 4'd5, if either operand lies outside [-2^30, 2^30), the flag stays low and the result is zero.
- R5: Opcodes 4'd6 (AND), 4'd7 (OR) and 4'd8 (XOR) always raise the flag and produce the full 64-bit bitwise result.
- R6: Opcodes 4'd9 to 4'd15 are unsupported. They leave the flag low and the result zero.
- R7: The result and the flag are registered. They reflect the inputs sampled at the rising edge where the issue strobe is high. In a cycle that follows an edge with no issue, the flag is low and the result is zero. Back-to-back issues each get their own result.
- R8: While reset (active low) is asserted, and right after it is released, the flag is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Operation strobe for this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| result_o | output | 64 | Registered fast result, zero when not valid |
| fast_ok_o | output | 1 | Registered flag: result_o is valid this cycle |

## Verification
The embedded properties check the following on every cycle:
- the flag is never raised without an issue on the previous edge;
- the zero-extended forms clear the upper half and the sign-extended forms copy bit 31 upward;
- out-of-window 64-bit operands and unsupported opcodes never raise the flag;
- logic operations always raise the flag.

The numeric correctness of each result can only be shown by the bench's scenarios, which compare against a reference model written in 64-bit signed arithmetic. These scenarios include:
- the exact window edges 2^30-1, 2^30, -2^30 and -2^30-1 on either operand;
- 32-bit wraparound;
- garbage in the upper halves of 32-bit operands;
- back-to-back issue.

// File: rtl/qalu_pkg.sv
package qalu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDW_S  = 4'd0,
    OP_SUBW_S  = 4'd1,
    OP_ADDW_Z  = 4'd2,
    OP_SUBW_Z  = 4'd3,
    OP_ADD_WIN = 4'd4,
    OP_SUB_WIN = 4'd5,
    OP_AND     = 4'd6,
    OP_OR      = 4'd7,
    OP_XOR     = 4'd8
  } qalu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } qalu_lsel_e;

  typedef struct packed {
    logic       known;     // opcode is in the fast set
    logic       is_win;    // 64-bit op needing the operand window
    logic       is_logic;  // bitwise group
    logic       subtract;  // arithmetic: a - b
    logic       zext;      // arithmetic: zero-extend narrow result
    qalu_lsel_e lsel;
  } qalu_dec_t;

  function automatic qalu_dec_t qalu_decode(logic [OP_W-1:0] op);
    qalu_dec_t d;
    d = '{known: 1'b0, is_win: 1'b0, is_logic: 1'b0, subtract: 1'b0,
          zext: 1'b0, lsel: LG_AND};
    case (op)
      OP_ADDW_S:  d.known = 1'b1;
      OP_SUBW_S:  begin d.known = 1'b1; d.subtract = 1'b1; end
      OP_ADDW_Z:  begin d.known = 1'b1; d.zext = 1'b1; end
      OP_SUBW_Z:  begin d.known = 1'b1; d.zext = 1'b1; d.subtract = 1'b1; end
      OP_ADD_WIN: begin d.known = 1'b1; d.is_win = 1'b1; end
      OP_SUB_WIN: begin d.known = 1'b1; d.is_win = 1'b1; d.subtract = 1'b1; end
      OP_AND:     begin d.known = 1'b1; d.is_logic = 1'b1; d.lsel = LG_AND; end
      OP_OR:      begin d.known = 1'b1; d.is_logic = 1'b1; d.lsel = LG_OR; end
      OP_XOR:     begin d.known = 1'b1; d.is_logic = 1'b1; d.lsel = LG_XOR; end
      default:    d.known = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/qalu_window.sv
// Flags an operand whose signed value lies in [-2^WIN_BIT, 2^WIN_BIT):
// every bit from WIN_BIT upward equals the sign bit.
module qalu_window #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned WIN_BIT = 30
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              in_win_o
);
  localparam int unsigned TOP_W = DATA_W - WIN_BIT;

  function automatic logic all_same(logic [TOP_W-1:0] v);
    return (&v) | ~(|v);
  endfunction

  logic [TOP_W-1:0] upper;
  assign upper    = val_i[DATA_W-1:WIN_BIT];
  assign in_win_o = all_same(upper);
endmodule

// File: rtl/qalu_narrow.sv
// Narrow add/subtract with sign or zero extension to the full width.
module qalu_narrow #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              subtract_i,
  input  logic              zext_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned EXT_W = DATA_W - NARROW_W;

  function automatic logic [NARROW_W-1:0] narrow_sum(
    logic [NARROW_W-1:0] x, logic [NARROW_W-1:0] y, logic sub);
    logic [NARROW_W-1:0] yy;
    yy = sub ? ~y : y;
    return x + yy + {{(NARROW_W-1){1'b0}}, sub};
  endfunction

  function automatic logic [DATA_W-1:0] widen(logic [NARROW_W-1:0] v, logic z);
    logic fill;
    fill = z ? 1'b0 : v[NARROW_W-1];
    return {{EXT_W{fill}}, v};
  endfunction

  logic [NARROW_W-1:0] sum_n;
  assign sum_n = narrow_sum(a_i[NARROW_W-1:0], b_i[NARROW_W-1:0], subtract_i);
  assign res_o = widen(sum_n, zext_i);

  logic unused_hi;
  assign unused_hi = ^{a_i[DATA_W-1:NARROW_W], b_i[DATA_W-1:NARROW_W]};
endmodule

// File: rtl/qalu_bitwise.sv
// Full-width bitwise unit, built per bit.
module qalu_bitwise
  import qalu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  qalu_lsel_e        lsel_i,
  output logic [DATA_W-1:0] res_o
);
  function automatic logic bit_op(logic x, logic y, qalu_lsel_e s);
    case (s)
      LG_OR:   return x | y;
      LG_XOR:  return x ^ y;
      default: return x & y;
    endcase
  endfunction

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign res_o[i] = bit_op(a_i[i], b_i[i], lsel_i);
  end
endmodule

// File: rtl/qalu_fast.sv
module qalu_fast
  import qalu_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              fast_ok_o
);
  // Window edge two bits below the narrow width: window sums cannot overflow.
  localparam int unsigned WIN_BIT = NARROW_W - 2;
  localparam int unsigned N_OPND  = 2;

  qalu_dec_t dec;
  assign dec = qalu_decode(op_i);

  // Operand window detectors, one per operand.
  logic [DATA_W-1:0] opnd [N_OPND];
  logic [N_OPND-1:0] in_win;
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar k = 0; k < N_OPND; k++) begin : g_win
    qalu_window #(.DATA_W(DATA_W), .WIN_BIT(WIN_BIT)) u_win (
      .val_i   (opnd[k]),
      .in_win_o(in_win[k])
    );
  end

  // Named internal events for the checks.
  logic both_in_win;
  logic win_reject;
  logic accept;
  assign both_in_win = &in_win;
  assign win_reject  = dec.is_win & ~both_in_win;
  assign accept      = dec.known & ~win_reject;

  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] next_res;

  qalu_narrow #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_narrow (
    .a_i       (a_i),
    .b_i       (b_i),
    .subtract_i(dec.subtract),
    .zext_i    (dec.zext),
    .res_o     (arith_res)
  );

  qalu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a_i   (a_i),
    .b_i   (b_i),
    .lsel_i(dec.lsel),
    .res_o (logic_res)
  );

  always_comb begin
    next_res = '0;
    if (issue_i && accept) next_res = dec.is_logic ? logic_res : arith_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_ok_o <= 1'b0;
      result_o  <= '0;
    end else begin
      fast_ok_o <= issue_i & accept;
      result_o  <= next_res;
    end
  end

  // ---------------- assertions ----------------
  localparam logic signed [DATA_W-1:0] WIN_HI = DATA_W'(64'sd1 <<< WIN_BIT);
  localparam logic signed [DATA_W-1:0] WIN_LO = -WIN_HI;

  assert_sext_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (op_i == OP_ADDW_S || op_i == OP_SUBW_S)) |=>
      (fast_ok_o && result_o[DATA_W-1:NARROW_W] == {(DATA_W-NARROW_W){result_o[NARROW_W-1]}}));

  assert_zext_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (op_i == OP_ADDW_Z || op_i == OP_SUBW_Z)) |=>
      (fast_ok_o && result_o[DATA_W-1:NARROW_W] == '0));

  assert_win_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (op_i == OP_ADD_WIN || op_i == OP_SUB_WIN) &&
     $signed(a_i) >= WIN_LO && $signed(a_i) < WIN_HI &&
     $signed(b_i) >= WIN_LO && $signed(b_i) < WIN_HI) |=> fast_ok_o);

  assert_win_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (op_i == OP_ADD_WIN || op_i == OP_SUB_WIN) &&
     ($signed(a_i) < WIN_LO || $signed(a_i) >= WIN_HI ||
      $signed(b_i) < WIN_LO || $signed(b_i) >= WIN_HI)) |=>
      (!fast_ok_o && result_o == '0));

  assert_logic_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> fast_ok_o);

  assert_unknown_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i > OP_XOR) |=> (!fast_ok_o && result_o == '0));

  assert_ok_needs_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!fast_ok_o && result_o == '0));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (!fast_ok_o && result_o == '0));

endmodule

// File: tb/qalu_fast_bench.sv
module qalu_fast_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;
  logic        fast_ok_o;

  qalu_fast u_qalu_fast (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .fast_ok_o(fast_ok_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  bit mon_on   = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  // Reference model: {flag, result}, written in signed 64-bit arithmetic.
  function automatic logic [64:0] model(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    longint sa = longint'(a);
    longint sb = longint'(b);
    longint lim = longint'(1) << 30;
    int     w;
    bit     ok_win = (sa >= -lim) && (sa < lim) && (sb >= -lim) && (sb < lim);
    case (op)
      4'd0: begin w = int'(a[31:0]) + int'(b[31:0]); return {1'b1, 64'(longint'(w))}; end
      4'd1: begin w = int'(a[31:0]) - int'(b[31:0]); return {1'b1, 64'(longint'(w))}; end
      4'd2: return {1'b1, 32'h0, 32'(a[31:0] + b[31:0])};
      4'd3: return {1'b1, 32'h0, 32'(a[31:0] - b[31:0])};
      4'd4: return ok_win ? {1'b1, 64'(sa + sb)} : 65'd0;
      4'd5: return ok_win ? {1'b1, 64'(sa - sb)} : 65'd0;
      4'd6: return {1'b1, a & b};
      4'd7: return {1'b1, a | b};
      4'd8: return {1'b1, a ^ b};
      default: return 65'd0;
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    @(negedge clk);
    issue_i = 1'b1; op_i = op; a_i = a; b_i = b;
    exp_q.push_back(model(op, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue_i = 1'b0; op_i = 4'hf; a_i = 64'hdead_beef_0123_4567; b_i = '1;
    end
  endtask

  task automatic check(input bit ok, input logic [63:0] res,
                       input logic [64:0] exp, input string tag);
    n_checks++;
    if (ok !== exp[64] || res !== exp[63:0]) begin
      n_fail++;
      $display("FAIL %s: got ok=%0b res=%h, expected ok=%0b res=%h",
               tag, ok, res, exp[64], exp[63:0]);
    end
  endtask

  // Monitor: one result per issued edge, idle edges must read clear (R7).
  initial begin
    bit pend;
    forever begin
      @(posedge clk);
      pend = issue_i && rst_n;
      @(negedge clk);
      if (mon_on) begin
        if (pend) begin
          if (exp_q.size() == 0) check(fast_ok_o, result_o, 65'd0, "R7 unexpected");
          else check(fast_ok_o, result_o, exp_q.pop_front(), tag_q.pop_front());
        end else begin
          check(fast_ok_o, result_o, 65'd0, "R7 idle");
        end
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(fast_ok_o, result_o, 65'd0, "R8 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(fast_ok_o, result_o, 65'd0, "R8 after release");
    mon_on = 1'b1;

    // R1: sign-extended 32-bit
    drive(4'd0, 64'h1234_5678_7fff_ffff, 64'hffff_0000_0000_0001, "R1 add wrap");
    drive(4'd1, 64'h0, 64'h1, "R1 sub negative");
    drive(4'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, "R1 add small");
    idle(1);
    // R2: zero-extended 32-bit
    drive(4'd2, 64'hffff_ffff_ffff_ffff, 64'h1, "R2 add wrap");
    drive(4'd3, 64'h0, 64'h1, "R2 sub");
    drive(4'd2, 64'h0000_0000_8000_0000, 64'hffff_ffff_0000_0001, "R2 add hi set");
    // R3: windowed 64-bit accepted at edges
    drive(4'd4, 64'h0000_0000_3fff_ffff, 64'h0000_0000_3fff_ffff, "R3 max+max");
    drive(4'd4, 64'hffff_ffff_c000_0000, 64'hffff_ffff_c000_0000, "R3 min+min");
    drive(4'd5, 64'h0000_0000_3fff_ffff, 64'hffff_ffff_c000_0000, "R3 max-min");
    drive(4'd5, 64'hffff_ffff_c000_0000, 64'h0000_0000_3fff_ffff, "R3 min-max");
    drive(4'd4, 64'hffff_ffff_ffff_fffb, 64'h3, "R3 neg small");
    // R4: rejected just outside the window and far outside
    drive(4'd4, 64'h0000_0000_4000_0000, 64'h1, "R4 a at 2^30");
    drive(4'd5, 64'h1, 64'hffff_ffff_bfff_ffff, "R4 b below -2^30");
    drive(4'd4, 64'h0000_0001_0000_0000, 64'h0, "R4 a large");
    drive(4'd5, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R4 both min");
    idle(2);
    // R5: full-width logic
    drive(4'd6, 64'hf0f0_1234_ffff_0000, 64'hff00_ff00_0f0f_ffff, "R5 and");
    drive(4'd7, 64'h8000_0000_0000_0001, 64'h0123_4567_89ab_cdef, "R5 or");
    drive(4'd8, 64'hffff_ffff_ffff_ffff, 64'haaaa_5555_aaaa_5555, "R5 xor");
    drive(4'd8, 64'h0000_0000_4000_0000, 64'h0000_0001_0000_0000, "R5 xor wide operands");
    // R6: unsupported opcodes
    drive(4'd9, 64'h1, 64'h2, "R6 op9");
    drive(4'd15, 64'hffff, 64'hffff, "R6 op15");
    // R7: back-to-back mix then idle
    drive(4'd0, 64'h10, 64'h20, "R7 b2b first");
    drive(4'd6, 64'hff, 64'h0f, "R7 b2b second");
    drive(4'd5, 64'h7, 64'h9, "R7 b2b third");
    idle(4);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R7: got %0d pending results, expected 0", exp_q.size());
    end
    summary();
  end
endmodule